// File: doc/BRIEF.md
# Text Scanline Renderer

This block turns a character screen of 80 columns by 25 rows into a stream of single-bit pixels, one scanline at a time. It holds two line stores of 100 bytes each. While one store is shifted out to the display, the block fills the other with the next scanline. For each of the 80 cells on a scanline, it takes the character code from an internal text array, picks one row of that glyph from an internal font array, and writes the resulting 8-pixel byte into the store. The first 20 bytes of each store are a blank lead-in that is never written.

A display timing generator drives the block. It pulses `line_done` at the end of every line and raises `vis_start` together with the line pulse on which rendering of a new frame must begin. From that point the block renders 400 scanlines: 16 glyph rows for each of the 25 text rows. It then spends two more lines zeroing both stores, and after that it stays quiet until the next frame start. Text and glyph contents are loaded through a one-cycle write port.

Top module: `txt_line_render`

## Requirements
- R1: While reset is held and after it is released, `pix_out` is 0 and both line stores read as zero, so the first line shown after reset is blank.
- R2: Each cycle with `pix_en` high shifts out one pixel. Pixel p of a line (counted from the last `line_done`) is bit 7-(p mod 8) of store byte p/8, which is most significant bit first, with 1 meaning foreground. `pix_out` does not change while `pix_en` is low, and it is 0 once all 800 pixels have been sent.
- R3: Every `line_done` swaps which store is shown. New bytes are written only into the store that is not being shown, so the scanline prepared during one line appears on the following line.
- R4: The byte for column c of a scanline is the font entry at address g*256 + code, where g is the glyph row and code is the text entry of that cell. It lands in store byte 20+c.
- R5: Store bytes 0 to 19 are never written, so the first 160 pixels of every line are 0.
- R6: A `line_done` with `vis_start` high restarts rendering at text row 0, glyph row 0, even in the middle of a frame.
- R7: Scanlines are rendered in order. Glyph rows run 0 to 15 within a text row and then move to the next text row, whose text index is 80 higher. The last scanline is text row 24, glyph row 15.
- R8: After the last scanline, the next two lines write zero over the pixel bytes of the hidden store, one store per line. Further lines write nothing until the next frame start.
- R9: One cell is processed per `pix_en` cycle, so a scanline is finished after 80 `pix_en` cycles following its `line_done`.
- R10: A write with `wr_en` high and `wr_font` at 0 stores `wr_data` in text entry `wr_addr` (row*80+col; addresses of 2000 and above are dropped). With `wr_font` at 1 the write goes to font entry `wr_addr`. A written value is used by every scanline rendered afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_en | input | 1 | Pixel-clock enable; one pixel and one cell per high cycle |
| line_done | input | 1 | Pulse at the end of each display line |
| vis_start | input | 1 | With `line_done`, marks the line where frame rendering begins |
| wr_en | input | 1 | Load strobe for text or font entry |
| wr_font | input | 1 | 0 selects the text array, 1 the font array |
| wr_addr | input | 12 | Entry index for the load |
| wr_data | input | 8 | Entry value for the load |
| pix_out | output | 1 | Serial pixel, 1 = foreground |

## Verification
The bench walks a complete frame with most lines cut to exactly 80 pixel enables. A renderer that is slower than one cell per enable would therefore leave a row half-written, and the sampled lines would show wrong glyph bytes. It samples the two rows on either side of the first text-row boundary and the very last scanline. A wrong text stride or an off-by-one in the glyph-row wrap then shows up as a mismatched byte pattern, and a renderer that stops early or writes one line too many fails on the last scanline. The three lines after the frame must be blank: skipping one of the two clearing passes would show stale pixels from the final row. A frame-start pulse in mid-frame must bring back glyph row 0, and a design that ignored it would show glyph row 6 instead. A pause in the enables mid-line and one extra enable at the end check that the serializer neither drifts nor emits bits past pixel 800.

// File: rtl/txt_render_pkg.sv
package txt_render_pkg;

    typedef enum logic [1:0] {
        M_IDLE   = 2'd0,
        M_RENDER = 2'd1,
        M_CLEAR  = 2'd2
    } fill_mode_e;

endpackage

// File: rtl/txt_glyph_store.sv
module txt_glyph_store #(
    parameter int COLS    = 80,
    parameter int ROWS    = 25,
    parameter int CELL_H  = 16,
    parameter int NGLYPH  = 256,
    parameter int ADDR_W  = 12,
    parameter int COL_W   = 7,
    parameter int ROW_W   = 5,
    parameter int GR_W    = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_font,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ROW_W-1:0]  rd_trow,
    input  logic [GR_W-1:0]   rd_grow,
    input  logic [COL_W-1:0]  rd_col,
    output logic [7:0]        rd_byte
);
    localparam int TXT_DEPTH  = COLS * ROWS;
    localparam int FONT_DEPTH = NGLYPH * CELL_H;
    localparam int TXT_AW     = $clog2(TXT_DEPTH);
    localparam int FONT_AW    = $clog2(FONT_DEPTH);

    logic [7:0] text_mem [TXT_DEPTH];
    logic [7:0] font_mem [FONT_DEPTH];

    logic [TXT_AW-1:0]  txt_idx;
    logic [FONT_AW-1:0] font_idx;
    logic [7:0]         code;

    // load port: text and glyph tables share one address/data path
    always_ff @(posedge clk) begin
        if (wr_en && !wr_font && (int'(wr_addr) < TXT_DEPTH)) begin
            text_mem[wr_addr[TXT_AW-1:0]] <= wr_data;
        end
        if (wr_en && wr_font && (int'(wr_addr) < FONT_DEPTH)) begin
            font_mem[wr_addr[FONT_AW-1:0]] <= wr_data;
        end
    end

    // cell lookup: code from text table, then glyph row laid out row-major
    always_comb begin
        txt_idx  = TXT_AW'(int'(rd_trow) * COLS + int'(rd_col));
        code     = text_mem[txt_idx];
        font_idx = FONT_AW'(int'(rd_grow) * NGLYPH + int'(code));
        rd_byte  = font_mem[font_idx];
    end

endmodule

// File: rtl/txt_line_bufs.sv
module txt_line_bufs #(
    parameter int LINE_BYTES = 100,
    parameter int IDX_W      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             wsel,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic             rsel,
    input  logic [IDX_W-1:0] ridx,
    output logic [7:0]       rdata
);
    logic [1:0][7:0] rd_each;

    for (genvar b = 0; b < 2; b++) begin : g_store
        localparam logic SEL = 1'(b);
        logic [7:0] bytes_q [LINE_BYTES];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < LINE_BYTES; i++) begin
                    bytes_q[i] <= 8'h00;
                end
            end else if (we && (wsel == SEL) && (int'(widx) < LINE_BYTES)) begin
                bytes_q[widx] <= wdata;
            end
        end

        assign rd_each[b] = (int'(ridx) < LINE_BYTES) ? bytes_q[ridx] : 8'h00;
    end

    assign rdata = rd_each[rsel];

endmodule

// File: rtl/txt_pixel_shift.sv
module txt_pixel_shift #(
    parameter int LINE_BYTES = 100,
    parameter int PIX_W      = 10,
    parameter int IDX_W      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_en,
    input  logic             line_done,
    input  logic [7:0]       rd_byte,
    output logic [IDX_W-1:0] rd_idx,
    output logic             pix_out
);
    localparam int LINE_PIX = LINE_BYTES * 8;
    localparam logic [PIX_W-1:0] END_POS = PIX_W'(LINE_PIX);

    typedef struct packed {
        logic [PIX_W-1:0] pos;
        logic             pix;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (line_done) begin
            sh_d.pos = '0;
        end else if (pix_en) begin
            if (sh_q.pos < END_POS) begin
                sh_d.pix = rd_byte[~sh_q.pos[2:0]];
                sh_d.pos = sh_q.pos + PIX_W'(1);
            end else begin
                sh_d.pix = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign rd_idx  = IDX_W'(sh_q.pos >> 3);
    assign pix_out = sh_q.pix;

endmodule

// File: rtl/txt_render_ctrl.sv
module txt_render_ctrl
    import txt_render_pkg::*;
#(
    parameter int COLS        = 80,
    parameter int ROWS        = 25,
    parameter int CELL_H      = 16,
    parameter int MARGIN      = 20,
    parameter int CLEAR_LINES = 2,
    parameter int COL_W       = 7,
    parameter int ROW_W       = 5,
    parameter int GR_W        = 4,
    parameter int IDX_W       = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_en,
    input  logic             line_done,
    input  logic             vis_start,
    output logic             disp_sel,
    output logic             busy,
    output logic             clearing,
    output logic             buf_we,
    output logic             buf_wsel,
    output logic [IDX_W-1:0] buf_widx,
    output logic [ROW_W-1:0] trow,
    output logic [GR_W-1:0]  grow,
    output logic [COL_W-1:0] col
);
    localparam int CL_W = $clog2(CLEAR_LINES + 1);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
    localparam logic [GR_W-1:0]  LAST_GR  = GR_W'(CELL_H - 1);

    typedef struct packed {
        fill_mode_e       mode;
        logic             disp;
        logic             busy;
        logic [ROW_W-1:0] trow;
        logic [GR_W-1:0]  grow;
        logic [COL_W-1:0] col;
        logic [CL_W-1:0]  clr_left;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  step;

    always_comb begin
        st_d = st_q;
        step = st_q.busy && pix_en && !line_done && (st_q.mode != M_IDLE);

        if (line_done) begin
            st_d.disp = ~st_q.disp;
            st_d.col  = '0;
            if (vis_start) begin
                st_d.mode     = M_RENDER;
                st_d.trow     = '0;
                st_d.grow     = '0;
                st_d.clr_left = '0;
                st_d.busy     = 1'b1;
            end else begin
                st_d.busy = (st_q.mode != M_IDLE);
            end
        end else if (step) begin
            if (st_q.col == LAST_COL) begin
                st_d.busy = 1'b0;
                st_d.col  = '0;
                if (st_q.mode == M_RENDER) begin
                    if (st_q.grow == LAST_GR) begin
                        st_d.grow = '0;
                        if (st_q.trow == LAST_ROW) begin
                            st_d.mode     = M_CLEAR;
                            st_d.trow     = '0;
                            st_d.clr_left = CL_W'(CLEAR_LINES);
                        end else begin
                            st_d.trow = st_q.trow + ROW_W'(1);
                        end
                    end else begin
                        st_d.grow = st_q.grow + GR_W'(1);
                    end
                end else begin
                    if (st_q.clr_left <= CL_W'(1)) begin
                        st_d.mode     = M_IDLE;
                        st_d.clr_left = '0;
                    end else begin
                        st_d.clr_left = st_q.clr_left - CL_W'(1);
                    end
                end
            end else begin
                st_d.col = st_q.col + COL_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign disp_sel = st_q.disp;
    assign busy     = st_q.busy;
    assign clearing = (st_q.mode == M_CLEAR);
    assign buf_we   = step;
    assign buf_wsel = ~st_q.disp;
    assign buf_widx = IDX_W'(MARGIN) + IDX_W'(st_q.col);
    assign trow     = st_q.trow;
    assign grow     = st_q.grow;
    assign col      = st_q.col;

endmodule

// File: rtl/txt_line_render.sv
module txt_line_render #(
    parameter int COLS        = 80,
    parameter int ROWS        = 25,
    parameter int CELL_H      = 16,
    parameter int NGLYPH      = 256,
    parameter int MARGIN      = 20,
    parameter int CLEAR_LINES = 2,
    localparam int LINE_BYTES = MARGIN + COLS,
    localparam int TXT_AW     = $clog2(COLS * ROWS),
    localparam int FONT_AW    = $clog2(NGLYPH * CELL_H),
    localparam int ADDR_W     = (FONT_AW > TXT_AW) ? FONT_AW : TXT_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en,
    input  logic              line_done,
    input  logic              vis_start,
    input  logic              wr_en,
    input  logic              wr_font,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              pix_out
);
    localparam int COL_W = $clog2(COLS);
    localparam int ROW_W = $clog2(ROWS);
    localparam int GR_W  = $clog2(CELL_H);
    localparam int IDX_W = $clog2(LINE_BYTES);
    localparam int PIX_W = $clog2(LINE_BYTES * 8 + 1);

    logic             disp_sel, busy, clearing;
    logic             buf_we, buf_wsel;
    logic [IDX_W-1:0] buf_widx, rd_idx;
    logic [7:0]       buf_wdata, glyph_byte, rd_byte;
    logic [ROW_W-1:0] trow;
    logic [GR_W-1:0]  grow;
    logic [COL_W-1:0] col;

    txt_render_ctrl #(
        .COLS(COLS), .ROWS(ROWS), .CELL_H(CELL_H), .MARGIN(MARGIN),
        .CLEAR_LINES(CLEAR_LINES), .COL_W(COL_W), .ROW_W(ROW_W),
        .GR_W(GR_W), .IDX_W(IDX_W)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_done(line_done),
        .vis_start(vis_start), .disp_sel(disp_sel), .busy(busy),
        .clearing(clearing), .buf_we(buf_we), .buf_wsel(buf_wsel),
        .buf_widx(buf_widx), .trow(trow), .grow(grow), .col(col)
    );

    txt_glyph_store #(
        .COLS(COLS), .ROWS(ROWS), .CELL_H(CELL_H), .NGLYPH(NGLYPH),
        .ADDR_W(ADDR_W), .COL_W(COL_W), .ROW_W(ROW_W), .GR_W(GR_W)
    ) glyph_i (
        .clk(clk), .wr_en(wr_en), .wr_font(wr_font), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_trow(trow), .rd_grow(grow), .rd_col(col),
        .rd_byte(glyph_byte)
    );

    assign buf_wdata = clearing ? 8'h00 : glyph_byte;

    txt_line_bufs #(
        .LINE_BYTES(LINE_BYTES), .IDX_W(IDX_W)
    ) bufs_i (
        .clk(clk), .rst_n(rst_n), .we(buf_we), .wsel(buf_wsel),
        .widx(buf_widx), .wdata(buf_wdata), .rsel(disp_sel),
        .ridx(rd_idx), .rdata(rd_byte)
    );

    txt_pixel_shift #(
        .LINE_BYTES(LINE_BYTES), .PIX_W(PIX_W), .IDX_W(IDX_W)
    ) shift_i (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_done(line_done),
        .rd_byte(rd_byte), .rd_idx(rd_idx), .pix_out(pix_out)
    );

endmodule

// File: rtl/txt_line_render_chk.sv
module txt_line_render_chk #(
    parameter int IDX_W      = 7,
    parameter int LINE_BYTES = 100,
    parameter int MARGIN     = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_en,
    input logic             line_done,
    input logic             pix_out,
    input logic             disp_sel,
    input logic             busy,
    input logic             buf_we,
    input logic [IDX_W-1:0] buf_widx
);
    logic rst_seen = 1'b0;

    always_ff @(posedge clk) begin
        if (!rst_n) rst_seen <= 1'b1;
    end

    always @(negedge clk) begin
        if (!rst_n && rst_seen) begin
            AST_RESET_QUIET: assert (pix_out == 1'b0) else $error("pixel high in reset"); // R1
        end
    end

    AST_PIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> $stable(pix_out)) else $error("pixel moved without enable"); // R2

    AST_SWAP_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> (disp_sel != $past(disp_sel))) else $error("no swap"); // R3

    AST_MARGIN_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> ((int'(buf_widx) >= MARGIN) && (int'(buf_widx) < LINE_BYTES)))
        else $error("write outside pixel region"); // R5

    AST_CELL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |=> (!busy || (buf_widx == IDX_W'(MARGIN)) ||
                    (buf_widx == IDX_W'($past(buf_widx) + 1'b1))))
        else $error("cell skipped"); // R9

    AST_LINE_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(line_done)) |-> ($past(buf_widx) == IDX_W'(LINE_BYTES - 1)))
        else $error("line ended early"); // R9

endmodule

bind txt_line_render txt_line_render_chk #(
    .IDX_W(IDX_W), .LINE_BYTES(LINE_BYTES), .MARGIN(MARGIN)
) chk_i (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_done(line_done),
    .pix_out(pix_out), .disp_sel(disp_sel), .busy(busy),
    .buf_we(buf_we), .buf_widx(buf_widx)
);

// File: tb/txt_line_render_tb_top.sv
`timescale 1ns/1ps
module txt_line_render_tb_top;

    logic        clk = 1'b0;
    logic        rst_n, pix_en, line_done, vis_start;
    logic        wr_en, wr_font;
    logic [11:0] wr_addr;
    logic [7:0]  wr_data;
    logic        pix_out;

    logic [7:0] text_m [2000];
    logic [7:0] font_m [4096];

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    txt_line_render dut_i (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_done(line_done),
        .vis_start(vis_start), .wr_en(wr_en), .wr_font(wr_font),
        .wr_addr(wr_addr), .wr_data(wr_data), .pix_out(pix_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic exp_pix(input int tr, input int gr, input int p);
        logic [7:0] b;
        int c;
        if (p < 160) return 1'b0;
        c = (p - 160) / 8;
        b = font_m[gr * 256 + int'(text_m[tr * 80 + c])];
        return b[7 - (p % 8)];
    endfunction

    task automatic wr(input bit fnt, input int addr, input logic [7:0] d);
        wr_en = 1'b1; wr_font = fnt; wr_addr = 12'(addr); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_line(input bit vs);
        line_done = 1'b1; vis_start = vs; pix_en = 1'b0;
        @(negedge clk);
        line_done = 1'b0; vis_start = 1'b0;
    endtask

    task automatic fast_line();
        pix_en = 1'b1;
        repeat (80) @(negedge clk);
        pix_en = 1'b0;
    endtask

    // shift out one whole line and compare every pixel
    task automatic check_line(input bit blank, input int tr, input int gr, input string req);
        int   bad_px = 0;
        int   first_p = 0;
        logic first_a = 1'b0;
        logic e;
        pix_en = 1'b1;
        for (int p = 0; p < 800; p++) begin
            @(negedge clk);
            e = blank ? 1'b0 : exp_pix(tr, gr, p);
            if (pix_out !== e) begin
                if (bad_px == 0) begin first_p = p; first_a = pix_out; end
                bad_px++;
            end
            if (p == 400) begin
                pix_en = 1'b0;
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk);
                    chk(pix_out === e, "R2", "hold while enable low", int'(pix_out), int'(e));
                end
                pix_en = 1'b1;
            end
        end
        chk(bad_px == 0, req, $sformatf("line row%0d/g%0d first bad pixel %0d", tr, gr, first_p),
            int'(first_a), int'(~first_a));
        @(negedge clk);
        chk(pix_out === 1'b0, "R2", "pixel past line end", int'(pix_out), 0);
        pix_en = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; pix_en = 1'b0; line_done = 1'b0; vis_start = 1'b0;
        wr_en = 1'b0; wr_font = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (5) @(negedge clk);
        chk(pix_out === 1'b0, "R1", "pixel during reset", int'(pix_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pix_out === 1'b0, "R1", "pixel after reset", int'(pix_out), 0);
    endtask

    task automatic t_load();
        for (int i = 0; i < 2000; i++) begin
            text_m[i] = 8'(i * 37 + 11);
            wr(1'b0, i, text_m[i]);
        end
        for (int a = 0; a < 4096; a++) begin
            font_m[a] = 8'(a * 29 + (a >> 8) * 5 + 3);
            wr(1'b1, a, font_m[a]);
        end
    endtask

    task automatic t_frame_walk();
        pulse_line(1'b1);
        check_line(1'b1, 0, 0, "R1 reset store blank");       // renders 0
        pulse_line(1'b0);
        check_line(1'b0, 0, 0, "R4 R3 first scanline");      // shows 0, renders 1
        pulse_line(1'b0);
        check_line(1'b0, 0, 1, "R7 glyph row step");          // shows 1, renders 2
        for (int j = 3; j <= 16; j++) begin
            pulse_line(1'b0);
            fast_line();
        end
        pulse_line(1'b0);
        check_line(1'b0, 1, 0, "R7 R9 next text row");        // shows 16
        for (int j = 18; j <= 399; j++) begin
            pulse_line(1'b0);
            fast_line();
        end
        pulse_line(1'b0);
        check_line(1'b0, 24, 15, "R7 last scanline");         // shows 399
        pulse_line(1'b0);
        check_line(1'b1, 0, 0, "R8 first cleared line");
        pulse_line(1'b0);
        check_line(1'b1, 0, 0, "R8 second cleared line");
        pulse_line(1'b0);
        check_line(1'b1, 0, 0, "R8 idle line");
    endtask

    task automatic t_next_frame();
        text_m[0] = 8'h5A;
        wr(1'b0, 0, 8'h5A);
        font_m[8'h5A] = 8'hC3;
        wr(1'b1, 8'h5A, 8'hC3);
        wr(1'b0, 2000, 8'hFF);                                 // dropped: out of range
        pulse_line(1'b1);
        fast_line();
        pulse_line(1'b0);
        check_line(1'b0, 0, 0, "R10 reloaded content");
    endtask

    task automatic t_restart_mid();
        for (int j = 2; j <= 5; j++) begin
            pulse_line(1'b0);
            fast_line();
        end
        pulse_line(1'b1);                                      // restart mid-frame
        fast_line();
        pulse_line(1'b0);
        check_line(1'b0, 0, 0, "R6 restart to row 0");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_load();
        t_frame_walk();
        t_next_frame();
        t_restart_mid();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule